// File: doc/BRIEF.md
# Microcoded Four-Phase 8-bit Processor Core

This block is a complete small processor. It holds four 8-bit working registers, an 8-bit program counter, a 16-bit instruction register and two condition flags (a carry/sign flag and a zero flag). Its program lives in an instruction ROM whose depth and contents are parameters of the top module. Every instruction word is 16 bits wide and runs in one machine cycle of four clock phases. A small microcode store turns the opcode into a control word during the decode phase, and that word steers the datapath in the execute phase.

The processor talks to the outside through two byte streams. The input stream is valid/ready. The core raises `in_ready` only in the execute phase of a read-input instruction. It holds `in_ready` and the whole machine still until the producer offers `in_valid`, and it takes the byte on the first rising edge where both are high. The output stream is also valid/ready. In the execute phase of a write-output instruction the core raises `out_valid` with the byte on `out_data`. Both stay steady for as long as `out_ready` is low, and they are released on the edge where both are high. With the consumer always ready, the output strobe lasts exactly one clock.

The default ROM image reads five signed bytes. It keeps a running minimum under the compare rule of R5 and emits the two's complement of that minimum. It then parks in a jump-to-self loop.

Top module: `mcpu_core`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released, `out_valid` and `in_ready` are low. Registers, flags and PC start at zero. With the default ROM the first `in_ready` appears 26 clocks after reset release.
- R2: Instruction fields: bits 15..12 opcode, bits 11..10 source register, bits 9..8 destination register, bits 7..0 immediate or absolute target. Register codes: 00 selects register 0, 01 register 1, 10 register 2, 11 register 3.
- R3: A machine cycle is four clocks: phase 0 fetches the word at PC into the instruction register and adds one to PC; phase 1 decodes; phase 2 executes; phase 3 idles. Without stalls every instruction takes exactly four clocks.
- R4: Opcode 0001 loads the immediate into Rd. Opcode 1000 copies Rs into Rd. Opcode 0101 reads the input byte into Rd. Opcode 1001 sends Rs to the output. Opcode 0000 and codes above 1001 do nothing except advance PC.
- R5: Opcode 0011 computes Rs minus Rd in 8 bits. It sets the carry/sign flag to bit 7 of that difference and the zero flag when the difference is zero, and it writes no register.
- R6: Opcode 0010 adds one to Rd modulo 256 and latches carry from the ninth result bit, plus zero. Opcode 0111 replaces Rd with its bitwise complement. Neither the complement nor the moves change the flags.
- R7: Opcode 0110 loads bits 7..0 into PC. Opcode 0100 does so only when the carry/sign flag is 0; otherwise execution falls through.
- R8: `in_ready` is high only in the execute phase of an input instruction. It stays high while `in_valid` is low, and the byte is taken on the edge where both are high.
- R9: `out_valid` is high only in the execute phase of an output instruction, and never together with `in_ready`. While `out_ready` is low, `out_valid` and `out_data` hold. With `out_ready` high the strobe lasts one clock.
- R10: With the default ROM the core accepts exactly five bytes. It emits one byte equal to the complement-plus-one of the minimum under R5 (the minimum starts at FF), then makes no further request or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Input stream byte |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Core waits for an input byte |
| out_data | output | 8 | Output stream byte |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Consumer takes the output byte |

## Verification
The stream handshake and the phase counter's advance out of the execute phase fall on the same edge, so a stalled input instruction must release the machine exactly once. This is provoked by answering the first request in the same cycle it rises in some runs, and twenty cycles later in others. The distance from each accepted byte to the next request is then judged against 24 or 32 clocks, depending on whether the jump of R7 was taken, and the distance to the result against 32 or 40 clocks. Output back-pressure is held across several cycles, and the byte is judged stable through it and gone one clock after release.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;
  localparam int WORD_W  = 8;
  localparam int INSN_W  = 16;
  localparam int RSEL_W  = 2;
  localparam int NUM_REG = 1 << RSEL_W;

  localparam logic [3:0] OP_LDI  = 4'h1;
  localparam logic [3:0] OP_INC  = 4'h2;
  localparam logic [3:0] OP_CMP  = 4'h3;
  localparam logic [3:0] OP_JNS  = 4'h4;
  localparam logic [3:0] OP_RDIN = 4'h5;
  localparam logic [3:0] OP_JMP  = 4'h6;
  localparam logic [3:0] OP_INV  = 4'h7;
  localparam logic [3:0] OP_MOV  = 4'h8;
  localparam logic [3:0] OP_WROUT = 4'h9;

  typedef enum logic [2:0] {
    FN_ADD  = 3'b000,
    FN_CMP  = 3'b001,
    FN_INC  = 3'b010,
    FN_INV  = 3'b100,
    FN_PASS = 3'b101
  } alu_fn_e;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_IMM = 2'd1,
    SRC_IN  = 2'd2
  } src_sel_e;

  typedef struct packed {
    logic     wr_reg;
    logic     wr_flags;
    alu_fn_e  fn;
    src_sel_e src;
    logic     jump;
    logic     jump_ns;
    logic     take_in;
    logic     give_out;
  } uword_t;

  localparam int DEF_DEPTH = 16;
  // word 0 in the low bits
  localparam logic [DEF_DEPTH*INSN_W-1:0] DEF_PROG = {
    16'h0000, 16'h600E, 16'h9400, 16'h2100,
    16'h7100, 16'h6003, 16'h8D00, 16'h4003,
    16'h3D00, 16'h5300, 16'h400B, 16'h3200,
    16'h2000, 16'h1206, 16'h11FF, 16'h1000
  };
endpackage

// File: rtl/mcpu_alu.sv
module mcpu_alu
  import mcpu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] res,
  output logic         cf,
  output logic         zf
);
  logic [W:0] wide;

  always_comb begin
    wide = '0;
    res  = x;
    cf   = 1'b0;
    unique case (fn)
      FN_ADD: begin
        wide = {1'b0, x} + {1'b0, y};
        res  = wide[W-1:0];
        cf   = wide[W];
      end
      FN_CMP: begin
        res = x - y;
        cf  = res[W-1];
      end
      FN_INC: begin
        wide = {1'b0, y} + (W+1)'(1);
        res  = wide[W-1:0];
        cf   = wide[W];
      end
      FN_INV:  res = ~y;
      FN_PASS: res = x;
      default: res = x;
    endcase
    zf = (res == '0);
  end
endmodule

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
  parameter int W    = 8,
  parameter int NREG = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [W-1:0]      wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [W-1:0]      rdata_a,
  output logic [W-1:0]      rdata_b,
  output logic [NREG*W-1:0] q_flat
);
  logic [W-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[g] <= '0;
      else if (we && waddr == AW'(g))
        q[g] <= wdata;
    end
    assign q_flat[g*W +: W] = q[g];
  end

  assign rdata_a = q[raddr_a];
  assign rdata_b = q[raddr_b];
endmodule

// File: rtl/mcpu_irom.sv
module mcpu_irom #(
  parameter int IW    = 16,
  parameter int AW    = 8,
  parameter int DEPTH = 16,
  parameter logic [DEPTH*IW-1:0] IMAGE = '0
) (
  input  logic [AW-1:0] addr,
  output logic [IW-1:0] data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (addr == AW'(i)) data = IMAGE[i*IW +: IW];
  end
endmodule

// File: rtl/mcpu_ucode.sv
module mcpu_ucode
  import mcpu_pkg::*;
(
  input  logic [3:0] opcode,
  output uword_t     uw
);
  always_comb begin
    uw = '0;
    case (opcode)
      OP_LDI:   begin uw.wr_reg = 1'b1; uw.fn = FN_PASS; uw.src = SRC_IMM; end
      OP_INC:   begin uw.wr_reg = 1'b1; uw.wr_flags = 1'b1; uw.fn = FN_INC; end
      OP_CMP:   begin uw.wr_flags = 1'b1; uw.fn = FN_CMP; end
      OP_JNS:   uw.jump_ns = 1'b1;
      OP_RDIN:  begin uw.wr_reg = 1'b1; uw.fn = FN_PASS; uw.src = SRC_IN; uw.take_in = 1'b1; end
      OP_JMP:   uw.jump = 1'b1;
      OP_INV:   begin uw.wr_reg = 1'b1; uw.fn = FN_INV; end
      OP_MOV:   begin uw.wr_reg = 1'b1; uw.fn = FN_PASS; uw.src = SRC_REG; end
      OP_WROUT: uw.give_out = 1'b1;
      default:  uw = '0;
    endcase
  end
endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
  import mcpu_pkg::*;
#(
  parameter int ROM_DEPTH = DEF_DEPTH,
  parameter logic [ROM_DEPTH*INSN_W-1:0] PROG = DEF_PROG
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready
);
  localparam int DATA_W = WORD_W;
  localparam int PC_W   = WORD_W;
  localparam int NREG   = NUM_REG;

  localparam logic [1:0] PH_FETCH  = 2'd0;
  localparam logic [1:0] PH_DECODE = 2'd1;
  localparam logic [1:0] PH_EXEC   = 2'd2;

  logic [1:0]         ph;
  logic [PC_W-1:0]    pc;
  logic [INSN_W-1:0]  ir;
  logic [INSN_W-1:0]  rom_word;
  uword_t             uw, uw_next;
  logic               flag_c, flag_z;
  logic               fire;

  logic [3:0]         f_op;
  logic [RSEL_W-1:0]  f_rs, f_rd;
  logic [7:0]         f_imm;
  assign f_op  = ir[15:12];
  assign f_rs  = ir[11:10];
  assign f_rd  = ir[9:8];
  assign f_imm = ir[7:0];

  logic [DATA_W-1:0]      rd_a, rd_b, op_x, alu_res;
  logic                   alu_c, alu_z;
  logic [NREG*DATA_W-1:0] rf_q;
  logic                   rf_we;

  mcpu_irom #(.IW(INSN_W), .AW(PC_W), .DEPTH(ROM_DEPTH), .IMAGE(PROG)) u_rom (
    .addr(pc), .data(rom_word)
  );

  mcpu_ucode u_ucode (.opcode(f_op), .uw(uw_next));

  mcpu_regfile #(.W(DATA_W), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(f_rd), .wdata(alu_res),
    .raddr_a(f_rs), .raddr_b(f_rd), .rdata_a(rd_a), .rdata_b(rd_b), .q_flat(rf_q)
  );

  always_comb begin
    unique case (uw.src)
      SRC_IMM: op_x = f_imm;
      SRC_IN:  op_x = in_data;
      default: op_x = rd_a;
    endcase
  end

  mcpu_alu #(.W(DATA_W)) u_alu (
    .fn(uw.fn), .x(op_x), .y(rd_b), .res(alu_res), .cf(alu_c), .zf(alu_z)
  );

  // execute phase completes unless a stream handshake is pending
  assign fire  = !(uw.take_in && !in_valid) && !(uw.give_out && !out_ready);
  assign rf_we = (ph == PH_EXEC) && fire && uw.wr_reg;

  assign in_ready  = (ph == PH_EXEC) && uw.take_in;
  assign out_valid = (ph == PH_EXEC) && uw.give_out;
  assign out_data  = out_valid ? rd_a : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_FETCH;
      pc     <= '0;
      ir     <= '0;
      uw     <= '0;
      flag_c <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      if (!(ph == PH_EXEC && !fire)) ph <= ph + 2'd1;
      case (ph)
        PH_FETCH: begin
          ir <= rom_word;
          pc <= pc + PC_W'(1);
        end
        PH_DECODE: uw <= uw_next;
        PH_EXEC: if (fire) begin
          if (uw.wr_flags) begin
            flag_c <= alu_c;
            flag_z <= alu_z;
          end
          if (uw.jump || (uw.jump_ns && !flag_c)) pc <= f_imm;
        end
        default: ;
      endcase
    end
  end

  logic unused_z;
  assign unused_z = flag_z;
endmodule

// File: rtl/mcpu_core_chk.sv
module mcpu_core_chk #(
  parameter int W    = 8,
  parameter int NREG = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        ph,
  input logic [7:0]        pc,
  input logic [15:0]       ir,
  input logic              cf,
  input logic [NREG*W-1:0] rf_q,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [W-1:0]      out_data
);
  function automatic logic [W-1:0] rv(input logic [1:0] idx, input logic [NREG*W-1:0] f);
    return f[int'(idx)*W +: W];
  endfunction

  function automatic logic sub_msb(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] d;
    d = a - b;
    return d[W-1];
  endfunction

  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != 2'd2) |=> (ph == $past(ph) + 2'd1));

  a_r3_fetch_incr: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd0) |=> (pc == $past(pc) + 8'd1));

  a_r7_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd2 && ir[15:12] == 4'h6) |=> (pc == $past(ir[7:0])));

  a_r5_cmp_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd2 && ir[15:12] == 4'h3) |=>
      ($stable(rf_q) && cf == $past(sub_msb(rv(ir[11:10], rf_q), rv(ir[9:8], rf_q)))));

  a_r6_inc_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd2 && ir[15:12] == 4'h2) |=> (cf == ($past(rv(ir[9:8], rf_q)) == '1)));

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && in_ready));
endmodule

bind mcpu_core mcpu_core_chk #(.W(DATA_W), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .ph(ph), .pc(pc), .ir(ir), .cf(flag_c), .rf_q(rf_q),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/mcpu_core_tb.sv
module mcpu_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b1;

  always #4 clk = ~clk;

  mcpu_core u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  // stimulus bytes, expected result, input stall, output hold
  localparam logic [7:0] VIN [4][5] = '{
    '{8'hF4, 8'h02, 8'hF1, 8'h10, 8'h20},
    '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05},
    '{8'h80, 8'hFF, 8'h90, 8'h81, 8'h7F},
    '{8'hFE, 8'hFD, 8'hFC, 8'hFB, 8'hFA}
  };
  localparam logic [7:0] VEXP [4] = '{8'h0F, 8'h01, 8'h81, 8'h06};
  localparam int VSTALL [4] = '{0, 20, 0, 3};
  localparam int VHOLD  [4] = '{0, 0, 7, 2};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !in_ready, "R1 quiet during reset", {out_valid, in_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !in_ready, "R1 quiet after release", {out_valid, in_ready}, 0);
  endtask

  task automatic wait_in(output bit ok);
    int n = 0;
    while (!in_ready && !out_valid && n < 300) begin
      @(negedge clk);
      n++;
    end
    ok = in_ready;
  endtask

  task automatic run_vector(input int vi);
    logic [7:0] r1, v, d, held;
    int exp_t, t_acc;
    bit ok, rep, seen;
    out_ready = (VHOLD[vi] == 0);
    do_reset();
    r1 = 8'hFF;
    exp_t = 26;
    t_acc = 0;
    for (int i = 0; i < 5; i++) begin
      wait_in(ok);
      chk(ok, "R8 input request raised", int'(ok), 1);
      chk(cyc == exp_t, (i == 0) ? "R1/R3 first request time" : "R3/R5/R7 request time",
          cyc, exp_t);
      if (i == 0 && VSTALL[vi] > 0) begin
        for (int s = 0; s < VSTALL[vi]; s++) @(negedge clk);
        chk(in_ready && !out_valid, "R8 request held while stalled", int'(in_ready), 1);
      end
      v = VIN[vi][i];
      in_data = v;
      in_valid = 1'b1;
      t_acc = cyc;
      @(negedge clk);
      in_valid = 1'b0;
      in_data = '0;
      chk(!in_ready, "R8 request drops after accept", int'(in_ready), 0);
      d = v - r1;
      rep = d[7];
      if (rep) r1 = v;
      exp_t = t_acc + (rep ? 32 : 24);
    end
    exp_t = exp_t + 8;
    seen = 1'b0;
    for (int n = 0; n < 100 && !out_valid; n++) begin
      @(negedge clk);
      if (in_ready) seen = 1'b1;
    end
    chk(!seen, "R10 no sixth input request", int'(seen), 0);
    chk(out_valid, "R9 output offered", int'(out_valid), 1);
    chk(cyc == exp_t, "R3/R10 result time", cyc, exp_t);
    chk(out_data == VEXP[vi], "R2/R4/R6/R10 result byte", out_data, VEXP[vi]);
    chk(out_data == 8'((~r1) + 8'd1), "R5 compare rule model", out_data, 8'((~r1) + 8'd1));
    if (VHOLD[vi] > 0) begin
      held = out_data;
      for (int k = 0; k < VHOLD[vi]; k++) begin
        @(negedge clk);
        chk(out_valid && out_data == held, "R9 hold under back-pressure", out_data, held);
      end
      out_ready = 1'b1;
      @(negedge clk);
      chk(!out_valid, "R9 release after accept", int'(out_valid), 0);
    end else begin
      @(negedge clk);
      chk(!out_valid, "R9 one-cycle strobe", int'(out_valid), 0);
    end
    seen = 1'b0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (out_valid || in_ready) seen = 1'b1;
    end
    chk(!seen, "R10 core parked after result", int'(seen), 0);
  endtask

  initial begin
    bit ok;
    for (int vi = 0; vi < 4; vi++) run_vector(vi);

    // directed: reset while a request is pending
    out_ready = 1'b1;
    do_reset();
    wait_in(ok);
    chk(ok && cyc == 26, "R1 request before abort", cyc, 26);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!in_ready && !out_valid, "R1 reset aborts request", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    wait_in(ok);
    chk(ok && cyc == 26, "R1 restart timing", cyc, 26);

    finish_run();
  end
endmodule